// File: doc/BRIEF.md
# Chip-Select Framed Serial Byte Receiver

This block takes bytes from an external master over a three-wire link made of an active-low chip select, a serial clock and a bidirectional data line. The three pins are asynchronous to the local sampling clock. Each pin first passes through a two-flop synchroniser. It then goes through a noise filter that changes its output level only when two consecutive samples agree. Short spikes on any pin are dropped.

While chip select is low, every filtered rising edge of the serial clock shifts in one data bit. Bits arrive least significant first. After the eighth bit the block presents the assembled byte together with a byte-end strobe that lasts one sampling cycle. A first-byte flag marks the first byte after chip select falls, so a command decoder can tell a command byte from the bytes that follow it. If chip select rises in the middle of a byte, the partial byte is discarded and the next frame starts from bit zero.

The block also drives the tri-state enable of the data pin. The enable can be high only when the surrounding logic requests output and the filtered chip select is low.

Top module: `cs_serial_rx`

## Requirements
- R1: During and right after reset, `rx_byte` is 0 and `byte_end`, `first_byte` and `sdata_oe` are low.
- R2: Bits are taken on filtered rising serial-clock edges while chip select is low. The first bit lands in `rx_byte[0]` and the eighth bit in `rx_byte[7]`.
- R3: After the eighth bit, `byte_end` is high for exactly one sampling cycle. `rx_byte` holds the new byte from that cycle until the next byte completes.
- R4: `first_byte` is high together with `byte_end` for the first byte after chip select falls. It is low for every later byte of the same frame, and low whenever `byte_end` is low.
- R5: If chip select rises before a byte is complete, that byte is discarded with no `byte_end`. The next frame starts counting at bit zero.
- R6: Serial-clock edges while chip select is high produce no `byte_end` and do not disturb the next frame.
- R7: A serial-clock spike that lasts one sampling cycle is not taken as an edge.
- R8: A data spike that lasts one sampling cycle and ends before the clock edge does not change the captured bit.
- R9: `sdata_oe` is high only while `dir_out` is high and the filtered chip select is low. It goes low within 8 sampling cycles of chip select rising.
- R10: A filtered level changes only after two consecutive synchronised samples agree on the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_in | input | 1 | Raw chip select, active low; reads high when floating |
| sclk_in | input | 1 | Raw serial clock, idles high |
| sdata_in | input | 1 | Raw serial data input |
| dir_out | input | 1 | Request from surrounding logic to drive the data pin |
| rx_byte | output | 8 | Last completed byte, LSB received first |
| byte_end | output | 1 | One-cycle strobe when a byte completes |
| first_byte | output | 1 | First byte of the frame, valid with `byte_end` |
| sdata_oe | output | 1 | Tri-state enable of the data pin |

## Verification
If the bit counter is left in a wrong state, the bytes that follow come out shifted or merged. This shows on `rx_byte` at the very next `byte_end`. It also shows as a missing or extra strobe across a frame that is cut short. A filter that accepts a single sample turns a one-cycle clock spike into an extra bit, so the byte goes wrong within the same frame. A stale first-byte flag or a leftover count shows on the first strobe of the following frame. A wrong output-enable state is visible on `sdata_oe` within a few cycles of chip select moving.

// File: rtl/cs_rx_pkg.sv
package cs_rx_pkg;
    localparam int BYTE_BITS = 8;
    localparam int CNT_W     = $clog2(BYTE_BITS);

    // pin order inside the filtered vector
    localparam int PIN_CS   = 0;
    localparam int PIN_SCLK = 1;
    localparam int PIN_DATA = 2;
    localparam int PIN_NUM  = 3;

    typedef struct packed {
        logic [BYTE_BITS-1:0] shreg;
        logic [CNT_W-1:0]     cnt;
        logic                 sclk_prev;
        logic                 first_pend;
        logic [BYTE_BITS-1:0] data;
        logic                 strobe;
        logic                 first;
    } asm_state_t;
endpackage

// File: rtl/cs_rx_sync.sv
module cs_rx_sync #(
    parameter int          WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.meta   = async_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.meta   <= RST_VAL;
            st_q.stable <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stable;
endmodule

// File: rtl/cs_rx_filter.sv
module cs_rx_filter #(
    parameter int          WIDTH   = 3,
    parameter int          SAMPLES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [WIDTH-1:0]         raw_i,
    output logic [WIDTH-1:0]         filt_o,
    output logic [WIDTH*SAMPLES-1:0] hist_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_pin
        logic [SAMPLES-1:0] hist_d, hist_q;
        logic               lvl_d, lvl_q;

        always_comb begin
            hist_d = {hist_q[SAMPLES-2:0], raw_i[g]};
            lvl_d  = lvl_q;
            if (&hist_q)
                lvl_d = 1'b1;
            else if (~|hist_q)
                lvl_d = 1'b0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hist_q <= {SAMPLES{RST_VAL[g]}};
                lvl_q  <= RST_VAL[g];
            end else begin
                hist_q <= hist_d;
                lvl_q  <= lvl_d;
            end
        end

        assign filt_o[g]                       = lvl_q;
        assign hist_o[g*SAMPLES +: SAMPLES]    = hist_q;
    end
endmodule

// File: rtl/cs_rx_assembler.sv
module cs_rx_assembler
    import cs_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_f,
    input  logic                 sclk_f,
    input  logic                 data_f,
    output logic [BYTE_BITS-1:0] byte_o,
    output logic                 strobe_o,
    output logic                 first_o
);
    asm_state_t st_d, st_q;
    logic       rise;

    assign rise = sclk_f & ~st_q.sclk_prev;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_f;
        st_d.strobe    = 1'b0;
        st_d.first     = 1'b0;
        if (cs_f) begin
            // idle: drop any partial byte, arm the first-byte flag
            st_d.shreg      = '0;
            st_d.cnt        = '0;
            st_d.first_pend = 1'b1;
        end else if (rise) begin
            st_d.shreg = {data_f, st_q.shreg[BYTE_BITS-1:1]};
            if (st_q.cnt == CNT_W'(BYTE_BITS-1)) begin
                st_d.cnt        = '0;
                st_d.data       = {data_f, st_q.shreg[BYTE_BITS-1:1]};
                st_d.strobe     = 1'b1;
                st_d.first      = st_q.first_pend;
                st_d.first_pend = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.shreg      <= '0;
            st_q.cnt        <= '0;
            st_q.sclk_prev  <= 1'b1;
            st_q.first_pend <= 1'b1;
            st_q.data       <= '0;
            st_q.strobe     <= 1'b0;
            st_q.first      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign byte_o   = st_q.data;
    assign strobe_o = st_q.strobe;
    assign first_o  = st_q.first;
endmodule

// File: rtl/cs_serial_rx.sv
module cs_serial_rx
    import cs_rx_pkg::*;
#(
    parameter int SAMPLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n_in,
    input  logic       sclk_in,
    input  logic       sdata_in,
    input  logic       dir_out,
    output logic [7:0] rx_byte,
    output logic       byte_end,
    output logic       first_byte,
    output logic       sdata_oe
);
    // chip select and clock idle high, data idles low
    localparam logic [PIN_NUM-1:0] IDLE_LVL = 3'b011;

    logic [PIN_NUM-1:0]         raw_pins, sync_pins, filt_pins;
    logic [PIN_NUM*SAMPLES-1:0] hist_all;
    logic                       oe_d, oe_q;

    assign raw_pins[PIN_CS]   = cs_n_in;
    assign raw_pins[PIN_SCLK] = sclk_in;
    assign raw_pins[PIN_DATA] = sdata_in;

    cs_rx_sync #(.WIDTH(PIN_NUM), .RST_VAL(IDLE_LVL)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_pins),
        .sync_o  (sync_pins)
    );

    cs_rx_filter #(.WIDTH(PIN_NUM), .SAMPLES(SAMPLES), .RST_VAL(IDLE_LVL)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (sync_pins),
        .filt_o (filt_pins),
        .hist_o (hist_all)
    );

    cs_rx_assembler u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_f     (filt_pins[PIN_CS]),
        .sclk_f   (filt_pins[PIN_SCLK]),
        .data_f   (filt_pins[PIN_DATA]),
        .byte_o   (rx_byte),
        .strobe_o (byte_end),
        .first_o  (first_byte)
    );

    always_comb oe_d = dir_out & ~filt_pins[PIN_CS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) oe_q <= 1'b0;
        else        oe_q <= oe_d;
    end

    assign sdata_oe = oe_q;
endmodule

// File: rtl/cs_serial_rx_chk.sv
module cs_serial_rx_chk #(
    parameter int HIST = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cs_f,
    input logic            sclk_f,
    input logic [HIST-1:0] sclk_hist,
    input logic            byte_end,
    input logic            first_byte,
    input logic            sdata_oe
);
    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_end |=> !byte_end);

    assert_strobe_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_end |-> !$past(cs_f));

    assert_first_with_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        first_byte |-> byte_end);

    assert_oe_off_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_f) |-> !sdata_oe);

    assert_filter_agree_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_f != $past(sclk_f)) |-> ($past(sclk_hist) == {HIST{sclk_f}}));
endmodule

bind cs_serial_rx cs_serial_rx_chk #(.HIST(SAMPLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_f       (filt_pins[cs_rx_pkg::PIN_CS]),
    .sclk_f     (filt_pins[cs_rx_pkg::PIN_SCLK]),
    .sclk_hist  (hist_all[cs_rx_pkg::PIN_SCLK*SAMPLES +: SAMPLES]),
    .byte_end   (byte_end),
    .first_byte (first_byte),
    .sdata_oe   (sdata_oe)
);

// File: tb/cs_serial_rx_test.sv
module cs_serial_rx_test;
    localparam int HOLD = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n_in = 1'b1, sclk_in = 1'b1, sdata_in = 1'b0, dir_out = 1'b0;
    logic [7:0] rx_byte;
    logic       byte_end, first_byte, sdata_oe;

    int checks = 0, errs = 0, ncap = 0, cycles = 0;
    logic [7:0] cap_b [0:255];
    logic       cap_f [0:255];
    logic [7:0] exp_b [0:7];
    bit         done = 1'b0;

    always #4 clk = ~clk;

    cs_serial_rx uut (
        .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n_in), .sclk_in(sclk_in),
        .sdata_in(sdata_in), .dir_out(dir_out), .rx_byte(rx_byte),
        .byte_end(byte_end), .first_byte(first_byte), .sdata_oe(sdata_oe)
    );

    always @(negedge clk) if (rst_n && byte_end) begin
        cap_b[ncap[7:0]] = rx_byte;
        cap_f[ncap[7:0]] = first_byte;
        ncap = ncap + 1;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000 && !done) begin
            errs = errs + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    function automatic logic exp_first(input int idx);
        return (idx == 0);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errs = errs + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // one bit: clock low with data set, optional spikes, then rising edge
    task automatic send_bit(input logic b, input bit dglitch, input bit cglitch);
        sclk_in = 1'b0; sdata_in = b;
        wait_cyc(HOLD);
        if (dglitch) begin
            sdata_in = ~b; wait_cyc(1); sdata_in = b; wait_cyc(2);
        end
        sclk_in = 1'b1;
        wait_cyc(HOLD);
        if (cglitch) begin
            sclk_in = 1'b0; wait_cyc(1); sclk_in = 1'b1; wait_cyc(HOLD);
        end
    endtask

    task automatic send_byte(input logic [7:0] v, input bit dg, input bit cg);
        for (int i = 0; i < 8; i++) send_bit(v[i], dg && i == 3, cg && i == 4);
    endtask

    task automatic frame(input int n, input string req, input bit dg, input bit cg);
        int base;
        base = ncap;
        cs_n_in = 1'b0; wait_cyc(12);
        for (int k = 0; k < n; k++) send_byte(exp_b[k], dg, cg);
        wait_cyc(10);
        cs_n_in = 1'b1; wait_cyc(12);
        check({req, " count"}, ncap - base, n);
        for (int k = 0; k < n; k++) begin
            check({req, " R2 byte"}, cap_b[(base + k) % 256], exp_b[k]);
            check({req, " R4 first"}, cap_f[(base + k) % 256], exp_first(k));
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        wait_cyc(3);
        check("R1 rx_byte", rx_byte, 0);
        check("R1 byte_end", byte_end, 0);
        check("R1 first_byte", first_byte, 0);
        check("R1 sdata_oe", sdata_oe, 0);
        rst_n = 1'b1;
        wait_cyc(4);
        check("R1 after reset strobe", byte_end, 0);

        // directed: LSB-first single byte
        exp_b[0] = 8'h01;
        frame(1, "R2 lsb", 1'b0, 1'b0);
        check("R3 held", rx_byte, 8'h01);

        // strobe width: only one cycle of byte_end per byte
        exp_b[0] = 8'hA5; exp_b[1] = 8'h3C; exp_b[2] = 8'hFF;
        frame(3, "R3 multi", 1'b0, 1'b0);

        // partial byte then idle
        begin
            int base;
            base = ncap;
            cs_n_in = 1'b0; wait_cyc(12);
            for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0, 1'b0);
            cs_n_in = 1'b1; wait_cyc(20);
            check("R5 no strobe", ncap - base, 0);
        end
        exp_b[0] = 8'h96;
        frame(1, "R5 fresh", 1'b0, 1'b0);

        // clock activity with chip select high
        begin
            int base;
            base = ncap;
            for (int i = 0; i < 16; i++) send_bit(i[0], 1'b0, 1'b0);
            check("R6 idle clocks", ncap - base, 0);
        end
        exp_b[0] = 8'h5A;
        frame(1, "R6 after", 1'b0, 1'b0);

        // spikes
        exp_b[0] = 8'hC3; exp_b[1] = 8'h0F;
        frame(2, "R7 clk spike", 1'b0, 1'b1);
        exp_b[0] = 8'h81; exp_b[1] = 8'h7E;
        frame(2, "R8 data spike", 1'b1, 1'b0);

        // output enable
        dir_out = 1'b1; wait_cyc(4);
        check("R9 idle oe", sdata_oe, 0);
        cs_n_in = 1'b0; wait_cyc(10);
        check("R9 active oe", sdata_oe, 1);
        dir_out = 1'b0; wait_cyc(2);
        check("R9 no request", sdata_oe, 0);
        dir_out = 1'b1; wait_cyc(2);
        cs_n_in = 1'b1; wait_cyc(8);
        check("R9 cs high oe", sdata_oe, 0);
        dir_out = 1'b0;
        // one-cycle chip select dip is filtered out
        cs_n_in = 1'b0; wait_cyc(1); cs_n_in = 1'b1;
        dir_out = 1'b1; wait_cyc(1);
        for (int i = 0; i < 8; i++) begin
            checks = checks + 1;
            if (sdata_oe !== 1'b0) begin
                errs = errs + 1;
                $display("FAIL R10 cs spike: actual=%0b expected=0", sdata_oe);
            end
            wait_cyc(1);
        end
        dir_out = 1'b0;

        // random frames
        for (int f = 0; f < 10; f++) begin
            int n;
            n = 1 + int'($urandom % 3);
            for (int k = 0; k < n; k++) exp_b[k] = 8'($urandom);
            frame(n, "R2 random", 1'b0, 1'b0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule